// File: doc/BRIEF.md
# Two-Way Interrupt Register Set for a Card-Side Link

This block holds the interrupt state that passes in both directions between a card host and the card-side (slave) logic. Toward the host it keeps eight pending flags, each set by a one-cycle pulse from slave logic. The host clears a flag by writing 1 to it in a clear register and can gate each flag with an enable mask. While any flag is both pending and enabled, the block pulls a level-sensitive, active-low request output low. The logic that times that level onto the data line is outside this block.

Toward the slave, the host writes an 8-bit doorbell register. Every bit that the write takes from 0 to 1 latches a request into an 8-bit sticky vector on the slave side. The slave clears that vector through its own write-1-to-clear port. The doorbell holds the written value for one cycle and then clears itself, so the host never has to clear it.

Host accesses use one write port and one combinational read port, each carrying a byte address and a byte/word size flag. The three 32-bit registers carry their flags in bits 7:0. The doorbell can be reached as a byte at its own address, or through its byte lane in a word access at the word-aligned address below it.

Top module: `bidir_irq_regs`

## Requirements
- R1: After reset the pending status is 0x00, the enable mask is 0xFF, the doorbell reads 0x00, the slave request vector is 0x00 and `host_irq_n` is 1.
- R2: A 1 on `src_set[i]` makes status bit i read 1 from the next cycle on, and the bit stays 1 until it is cleared; status is read at address 0x058, bits 7:0.
- R3: A write to address 0x0D4 clears each status bit whose data bit (bits 7:0) is 1; bits written 0 leave status unchanged; reading 0x0D4 returns zero.
- R4: When `src_set[i]` and a clear write of bit i fall in the same cycle, status bit i is 1 afterwards.
- R5: The enable mask is written and read at address 0x0DC, bits 7:0; a write takes effect from the next cycle.
- R6: `host_irq_n` is 0 exactly when some bit is 1 in both status and mask, and 1 otherwise; it follows the registers in the same cycle.
- R7: A host write to the doorbell, either as a byte write at 0x08D using data bits 7:0 or as a word write at 0x08C using data bits 15:8, sets `slv_irq[i]` on the next cycle for every bit i that goes from 0 to 1 in the doorbell; bits already 1, and bits written 0, set nothing.
- R8: The doorbell reads back the written value in the cycle after the write (byte read at 0x08D, bits 7:0; word read at 0x08C, bits 15:8) and reads 0x00 from the cycle after that, unless it is written again.
- R9: `slv_irq` bits stay set until a 1 on the matching `slv_clr` bit clears them; a new doorbell rise in the same cycle as a clear wins and leaves the bit set.
- R10: A read of any address outside the mapped set returns zero, and the unused upper bits of mapped registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 12 | Host write byte address |
| wr_word | input | 1 | 1 for a 32-bit write, 0 for a byte write |
| wr_data | input | 32 | Host write data |
| rd_addr | input | 12 | Host read byte address |
| rd_word | input | 1 | 1 for a 32-bit read, 0 for a byte read |
| rd_data | output | 32 | Host read data, combinational |
| src_set | input | 8 | Slave-side pulses that set status flags |
| host_irq_n | output | 1 | Active-low level request toward the host |
| slv_irq | output | 8 | Sticky doorbell requests toward slave logic |
| slv_clr | input | 8 | Slave write-1-to-clear for `slv_irq` |

## Verification
On every cycle the embedded assertions check that a set pulse leaves its status bit pending, and that a set pulse beats a clear write in the same cycle. They also check that clear bits written 0 change nothing, that the mask changes only when it is written, that the doorbell falls back to zero when it is not written, and that every 0-to-1 doorbell edge lands in the slave vector. The read address map cannot be shown by a per-cycle property, and neither can the full relation between every status/mask combination and the request level. Nor can the word-lane access to the doorbell or the no-new-edge case of back-to-back writes. The bench shows these through its sweeps over mask, status and doorbell values.

// File: rtl/bidir_irq_regs.sv
module bidir_irq_regs #(
  parameter int              NSRC    = 8,
  parameter int              ADDR_W  = 12,
  parameter logic [11:0]     A_STAT  = 12'h058,
  parameter logic [11:0]     A_CLR   = 12'h0D4,
  parameter logic [11:0]     A_MASK  = 12'h0DC,
  parameter logic [11:0]     A_DOOR  = 12'h08D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_word,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_word,
  output logic [31:0]       rd_data,
  input  logic [NSRC-1:0]   src_set,
  output logic              host_irq_n,
  output logic [7:0]        slv_irq,
  input  logic [7:0]        slv_clr
);

  localparam int              LANE   = int'(A_DOOR[1:0]);
  localparam logic [ADDR_W-1:0] DOOR_B = ADDR_W'(A_DOOR);
  localparam logic [ADDR_W-1:0] DOOR_W = ADDR_W'({A_DOOR[11:2], 2'b00});
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(A_STAT);
  localparam logic [ADDR_W-1:0] CLR_A  = ADDR_W'(A_CLR);
  localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(A_MASK);

  logic [NSRC-1:0] stat_q, mask_q;
  logic [7:0]      door_q;

  wire clr_hit  = wr_en && (wr_addr == CLR_A);
  wire mask_hit = wr_en && (wr_addr == MASK_A);
  wire door_hit = wr_en && (wr_word ? (wr_addr == DOOR_W) : (wr_addr == DOOR_B));

  wire [NSRC-1:0] clr_bits  = clr_hit ? wr_data[NSRC-1:0] : '0;
  wire [7:0]      door_val  = wr_word ? wr_data[8*LANE +: 8] : wr_data[7:0];
  wire [7:0]      door_rise = door_hit ? (door_val & ~door_q) : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      mask_q  <= '1;
      door_q  <= 8'h00;
      slv_irq <= 8'h00;
    end else begin
      stat_q  <= (stat_q & ~clr_bits) | src_set;
      if (mask_hit) mask_q <= wr_data[NSRC-1:0];
      door_q  <= door_hit ? door_val : 8'h00;
      slv_irq <= (slv_irq & ~slv_clr) | door_rise;
    end
  end

  assign host_irq_n = ~|(stat_q & mask_q);

  always_comb begin
    rd_data = 32'h0;
    if (rd_addr == STAT_A)
      rd_data[NSRC-1:0] = stat_q;
    else if (rd_addr == MASK_A)
      rd_data[NSRC-1:0] = mask_q;
    else if (rd_word && rd_addr == DOOR_W)
      rd_data[8*LANE +: 8] = door_q;
    else if (!rd_word && rd_addr == DOOR_B)
      rd_data[7:0] = door_q;
  end

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_set) |=> ((stat_q & $past(src_set)) == $past(src_set))); // R2

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && |(src_set & wr_data[NSRC-1:0])) |=>
      ((stat_q & $past(src_set & wr_data[NSRC-1:0])) == $past(src_set & wr_data[NSRC-1:0]))); // R4

  AST_ZERO_CLEAR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> ((stat_q & $past(stat_q & ~wr_data[NSRC-1:0])) == $past(stat_q & ~wr_data[NSRC-1:0]))); // R3

  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_hit |=> $stable(mask_q)); // R5

  AST_LINE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && ((stat_q & ~wr_data[NSRC-1:0]) == '0) && (src_set == '0) && !mask_hit) |=> host_irq_n); // R6

  AST_DOOR_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !door_hit |=> (door_q == 8'h00)); // R8

  AST_RISE_REACHES_SLAVE: assert property (@(posedge clk) disable iff (!rst_n)
    door_hit |=> ((slv_irq & $past(door_val & ~door_q)) == $past(door_val & ~door_q))); // R7

  AST_SLV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (slv_clr == 8'h00) |=> ((slv_irq & $past(slv_irq)) == $past(slv_irq))); // R9

endmodule

// File: tb/bidir_irq_regs_tb.sv
module bidir_irq_regs_tb_top;
  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0, wr_word = 0, rd_word = 0;
  logic [11:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic [7:0]  src_set = 0, slv_irq, slv_clr = 0;
  logic        host_irq_n;
  int          n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  bidir_irq_regs dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_word(wr_word),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_word(rd_word), .rd_data(rd_data),
    .src_set(src_set), .host_irq_n(host_irq_n), .slv_irq(slv_irq), .slv_clr(slv_clr));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic rd(input logic [11:0] a, input logic w, output logic [31:0] d);
    rd_addr = a; rd_word = w; #1; d = rd_data;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic w);
    wr_en = 1; wr_addr = a; wr_data = d; wr_word = w;
    tick();
    wr_en = 0; wr_data = 0;
  endtask

  task automatic pulse(input logic [7:0] s);
    src_set = s; tick(); src_set = 0;
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    #5 rst_n = 1; tick();
    rd(12'h058, 1, d); chk(d, 0, "R1 status");
    rd(12'h0DC, 1, d); chk(d, 32'hFF, "R1 mask");
    rd(12'h08D, 0, d); chk(d, 0, "R1 door");
    chk(slv_irq, 0, "R1 slv_irq");
    chk(host_irq_n, 1, "R1 line");

    pulse(8'h08);
    rd(12'h058, 1, d); chk(d, 32'h08, "R2 set");
    chk(host_irq_n, 0, "R6 line active");
    tick(); tick();
    rd(12'h058, 0, d); chk(d, 32'h08, "R2 sticky");

    wr(12'h0D4, 32'hFFFF_FFF7, 1);
    rd(12'h058, 1, d); chk(d, 32'h08, "R3 zero bit no effect");
    rd(12'h0D4, 1, d); chk(d, 0, "R3 clear reads zero");
    wr(12'h0D4, 32'h08, 1);
    rd(12'h058, 1, d); chk(d, 0, "R3 cleared");
    chk(host_irq_n, 1, "R6 line released");

    src_set = 8'h10; wr(12'h0D4, 32'h10, 1); src_set = 0;
    rd(12'h058, 1, d); chk(d, 32'h10, "R4 set wins");
    wr(12'h0D4, 32'hFF, 1);

    for (int s = 0; s < 256; s += 15) begin
      wr(12'h0D4, 32'hFF, 1);
      pulse(8'(s));
      for (int m = 0; m < 256; m++) begin
        wr(12'h0DC, 32'(m), (m % 2) == 0);
        rd(12'h0DC, 1, d); chk(d, 32'(m), "R5 mask readback");
        chk(host_irq_n, ((s & m) == 0) ? 1 : 0, "R6 line level");
      end
    end
    wr(12'h0DC, 32'hFF, 0);
    wr(12'h0D4, 32'hFF, 0);
    chk(host_irq_n, 1, "R6 all cleared");

    for (int v = 0; v < 256; v++) begin
      wr(12'h08D, 32'hA500 | 32'(v), 0);
      chk(slv_irq, 32'(v), "R7 byte doorbell");
      rd(12'h08D, 0, d); chk(d, 32'(v), "R8 door readback");
      tick();
      rd(12'h08D, 0, d); chk(d, 0, "R8 door self clear");
      chk(slv_irq, 32'(v), "R9 slv sticky");
      slv_clr = 8'hFF; tick(); slv_clr = 0;
      chk(slv_irq, 0, "R9 slv clear");
    end

    for (int v = 1; v < 256; v += 37) begin
      wr(12'h08C, (32'(v) << 8) | 32'h5A, 1);
      chk(slv_irq, 32'(v), "R7 word doorbell");
      rd(12'h08C, 1, d); chk(d, 32'(v) << 8, "R8 word readback");
      slv_clr = 8'hFF; tick(); slv_clr = 0;
    end

    wr(12'h08D, 32'h01, 0);
    slv_clr = 8'h01; wr(12'h08D, 32'h01, 0); slv_clr = 0;
    chk(slv_irq, 0, "R7 no new rise back-to-back");

    slv_clr = 8'h02; wr(12'h08D, 32'h02, 0); slv_clr = 0;
    chk(slv_irq, 32'h02, "R9 rise beats clear");
    slv_clr = 8'hFF; tick(); slv_clr = 0;
    wr(12'h08D, 32'h00, 0);
    chk(slv_irq, 0, "R7 zero write no request");

    pulse(8'hFF);
    rd(12'h100, 1, d); chk(d, 0, "R10 unmapped");
    rd(12'h058, 1, d); chk(d, 32'hFF, "R10 upper bits zero");
    rd(12'h08C, 0, d); chk(d, 0, "R10 byte at word door address");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule